// File: doc/BRIEF.md
# Sequential Target Comparator

The block holds a table of up to 48 entries. Each entry pairs a 32-bit target value with an 8-bit task number. Once started, it compares the incoming counter value against one entry only: the active one. When the counter equals that target, it posts an interrupt request that carries the entry's task number, and the active index moves to the next entry. When the index passes the last registered entry, it wraps back to entry 0.

The table is loaded through a write port while comparison is stopped. A separate count register sets how many entries are in use. Start and stop strobes control the comparison. A request stays posted, with its task number held, until the consumer acknowledges it. If a second match arrives before that acknowledge, a sticky flag records the lost request.

Top module: `tgt_seq_cmp`

## Requirements
- R1: A table write while stopped, with `tbl_idx_i` below 48, stores the target and the task in that entry. A later match on that entry returns the stored task.
- R2: While running, a cycle with `pv_i` equal to the active target sets `req_o` on the next edge, and `req_task_o` then shows that entry's task.
- R3: Each match moves `idx_o` to `idx_o+1`. When `idx_o+1` is equal to or greater than the count, `idx_o` goes to 0 instead.
- R4: A change of `pv_i` that does not equal the active target, including a drop to zero, changes neither `idx_o`, `run_o` nor the table.
- R5: The count resets to 1. A count write of 1 to 48 is taken. A count write of 0 or 49..63 leaves `cnt_o` unchanged.
- R6: `start_i` alone sets `run_o`, clears `idx_o` to 0 and clears `ovf_o`. `stop_i` clears `run_o` and holds `idx_o`. When both are high, stop wins. No match is taken in a cycle with either strobe high.
- R7: `req_o` and `req_task_o` hold until `ack_i`, which clears `req_o` on the next edge. A match in the same cycle as `ack_i` posts the new request.
- R8: A match while `req_o` is high and `ack_i` is low sets `ovf_o`. The flag stays set until a start, and `req_task_o` takes the newer task.
- R9: Table writes while `run_o` is high are ignored.
- R10: After reset: `run_o`=0, `idx_o`=0, `cnt_o`=1, `req_o`=0, `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 6 | Entry to write |
| tbl_tgt_i | input | 32 | Target value to write |
| tbl_tsk_i | input | 8 | Task number to write |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_val_i | input | 6 | New entry count |
| start_i | input | 1 | Start comparison from entry 0 |
| stop_i | input | 1 | Stop comparison, hold index |
| pv_i | input | 32 | Live counter value |
| ack_i | input | 1 | Request acknowledge |
| req_o | output | 1 | Interrupt request pending |
| req_task_o | output | 8 | Task number of the request |
| ovf_o | output | 1 | Sticky lost-request flag |
| run_o | output | 1 | Comparison running |
| idx_o | output | 6 | Active entry index |
| cnt_o | output | 6 | Registered entry count |

## Verification
A wrong active index has two visible effects. It shows on `idx_o` one edge after the faulty match. It also shows as a missed or unexpected request on the next matching cycle, with a task number that does not match the entry expected. A faulty run state or count shows as a request that should not appear, or one that is absent, one cycle later. A table cell that is corrupt stays hidden until the index reaches that entry, so the bench sweeps every entry with the count at 48. The bench compares all outputs against its model on every cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int DEPTH_D = 48;
  localparam int TGT_W_D = 32;
  localparam int TSK_W_D = 8;
endpackage

// File: rtl/tsc_table.sv
module tsc_table #(
  parameter int DEPTH = 48,
  parameter int TGT_W = 32,
  parameter int TSK_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TGT_W-1:0] wr_tgt_i,
  input  logic [TSK_W-1:0] wr_tsk_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TGT_W-1:0] rd_tgt_o,
  output logic [TSK_W-1:0] rd_tsk_o
);
  logic [DEPTH-1:0][TGT_W-1:0] tgt_q;
  logic [DEPTH-1:0][TSK_W-1:0] tsk_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel;
    assign sel = we_i && !run_i && (wr_idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_q[i] <= '0;
        tsk_q[i] <= '0;
      end else if (sel) begin
        tgt_q[i] <= wr_tgt_i;
        tsk_q[i] <= wr_tsk_i;
      end
    end
  end

  always_comb begin
    rd_tgt_o = '0;
    rd_tsk_o = '0;
    if (32'(rd_idx_i) < DEPTH) begin
      rd_tgt_o = tgt_q[rd_idx_i];
      rd_tsk_o = tsk_q[rd_idx_i];
    end
  end

  // R9: a running comparison freezes the table
  p_no_wr_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(tgt_q) && $stable(tsk_q)));
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl #(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             eq_i,
  output logic             hit_o,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_ok, last;

  assign cnt_ok = cnt_we_i && (cnt_val_i != '0) && (32'(cnt_val_i) <= DEPTH);
  assign last   = (32'(idx_q) + 1) >= 32'(cnt_q);
  assign hit_o  = run_q && eq_i && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= CNT_W'(1);
    end else begin
      if (cnt_ok) cnt_q <= cnt_val_i;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i) begin
        run_q <= 1'b1;
        idx_q <= '0;
      end else if (hit_o) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign idx_o = idx_q;
  assign cnt_o = cnt_q;

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (run_q && idx_q == '0));
  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!run_q && idx_q == $past(idx_q)));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !last) |=> (idx_q == $past(idx_q) + 1'b1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && last) |=> (idx_q == '0));
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eq_i && !start_i && !stop_i) |=> ($stable(idx_q) && $stable(run_q)));
  p_cnt_bad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && (cnt_val_i == '0 || 32'(cnt_val_i) > DEPTH)) |=> $stable(cnt_q));
  p_idx_rng_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < DEPTH);
endmodule

// File: rtl/tsc_irq.sv
module tsc_irq #(
  parameter int TSK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [TSK_W-1:0] task_i,
  input  logic             ack_i,
  input  logic             clr_i,
  output logic             req_o,
  output logic [TSK_W-1:0] task_o,
  output logic             ovf_o
);
  logic             req_q, ovf_q;
  logic [TSK_W-1:0] task_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
      task_q <= '0;
    end else begin
      if (hit_i) begin
        req_q  <= 1'b1;
        task_q <= task_i;
      end else if (ack_i) begin
        req_q  <= 1'b0;
      end
      if (clr_i) ovf_q <= 1'b0;
      else if (hit_i && req_q && !ack_i) ovf_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign task_o = task_q;
  assign ovf_o  = ovf_q;

  p_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (req_q && task_q == $past(task_i)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i && !hit_i) |=> (req_q && $stable(task_q)));
  p_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit_i) |=> !req_q);
  p_ovf_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && req_q && !ack_i) |=> ovf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/tgt_seq_cmp.sv
module tgt_seq_cmp
  import tsc_pkg::*;
#(
  parameter int DEPTH = DEPTH_D,
  parameter int TGT_W = TGT_W_D,
  parameter int TSK_W = TSK_W_D,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [TGT_W-1:0] tbl_tgt_i,
  input  logic [TSK_W-1:0] tbl_tsk_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [TGT_W-1:0] pv_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [TSK_W-1:0] req_task_o,
  output logic             ovf_o,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [TGT_W-1:0] act_tgt;
  logic [TSK_W-1:0] act_tsk;
  logic             hit, run;
  logic [IDX_W-1:0] idx;

  tsc_table #(.DEPTH(DEPTH), .TGT_W(TGT_W), .TSK_W(TSK_W), .IDX_W(IDX_W)) i_table (
    .clk_i, .rst_ni,
    .run_i    (run),
    .we_i     (tbl_we_i),
    .wr_idx_i (tbl_idx_i),
    .wr_tgt_i (tbl_tgt_i),
    .wr_tsk_i (tbl_tsk_i),
    .rd_idx_i (idx),
    .rd_tgt_o (act_tgt),
    .rd_tsk_o (act_tsk)
  );

  tsc_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni,
    .start_i, .stop_i, .cnt_we_i, .cnt_val_i,
    .eq_i  (pv_i == act_tgt),
    .hit_o (hit),
    .run_o (run),
    .idx_o (idx),
    .cnt_o (cnt_o)
  );

  tsc_irq #(.TSK_W(TSK_W)) i_irq (
    .clk_i, .rst_ni,
    .hit_i  (hit),
    .task_i (act_tsk),
    .ack_i,
    .clr_i  (start_i && !stop_i),
    .req_o,
    .task_o (req_task_o),
    .ovf_o
  );

  assign run_o = run;
  assign idx_o = idx;
endmodule

// File: tb/test_tgt_seq_cmp.sv
module test_tgt_seq_cmp;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tbl_we = 0, cnt_we = 0, start = 0, stop = 0, ack = 0;
  logic [5:0]  tbl_idx = 0, cnt_val = 0;
  logic [31:0] tbl_tgt = 0, pv = 0;
  logic [7:0]  tbl_tsk = 0;
  logic        req, ovf, run;
  logic [7:0]  rtask;
  logic [5:0]  idx, cnt;

  int total = 0, bad = 0, cyc_n = 0;
  bit done = 0;

  // reference model
  int unsigned m_tgt[48];
  int          m_tsk[48];
  bit m_run, m_req, m_ovf;
  int m_idx, m_cnt, m_task;

  always #4 clk = ~clk;

  tgt_seq_cmp i_tgt_seq_cmp (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx),
    .tbl_tgt_i(tbl_tgt), .tbl_tsk_i(tbl_tsk), .cnt_we_i(cnt_we), .cnt_val_i(cnt_val),
    .start_i(start), .stop_i(stop), .pv_i(pv), .ack_i(ack),
    .req_o(req), .req_task_o(rtask), .ovf_o(ovf), .run_o(run), .idx_o(idx), .cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int nxt_idx(input int i, input int c);
    return (i + 1 >= c) ? 0 : i + 1;
  endfunction

  task automatic cmp_all();
    chk(run == m_run, "R6", "run", run, m_run);
    chk(int'(idx) == m_idx, "R3", "idx", idx, m_idx);
    chk(int'(cnt) == m_cnt, "R5", "cnt", cnt, m_cnt);
    chk(req == m_req, "R7", "req", req, m_req);
    if (m_req) chk(int'(rtask) == m_task, "R2", "task", rtask, m_task);
    chk(ovf == m_ovf, "R8", "ovf", ovf, m_ovf);
  endtask

  // one clock: model update from current inputs, then compare
  task automatic cyc();
    bit hit;
    hit = m_run && !start && !stop && (pv == m_tgt[m_idx]);
    if (tbl_we && !m_run && tbl_idx < 48) begin
      m_tgt[tbl_idx] = tbl_tgt;
      m_tsk[tbl_idx] = int'(tbl_tsk);
    end
    if (start && !stop) m_ovf = 0;
    else if (hit && m_req && !ack) m_ovf = 1;
    if (hit) begin m_req = 1; m_task = m_tsk[m_idx]; end
    else if (ack) m_req = 0;
    if (stop) m_run = 0;
    else if (start) begin m_run = 1; m_idx = 0; end
    else if (hit) m_idx = nxt_idx(m_idx, m_cnt);
    if (cnt_we && cnt_val >= 1 && cnt_val <= 48) m_cnt = int'(cnt_val);
    @(posedge clk);
    @(negedge clk);
    tbl_we = 0; cnt_we = 0; start = 0; stop = 0; ack = 0;
    cmp_all();
  endtask

  task automatic wr_ent(input int i, input int unsigned t, input int k);
    tbl_we = 1; tbl_idx = 6'(i); tbl_tgt = t; tbl_tsk = 8'(k);
    cyc();
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1; cnt_val = 6'(v);
    cyc();
  endtask

  initial begin : watchdog
    while (!done && cyc_n < 150000) begin @(posedge clk); cyc_n++; end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc_n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    foreach (m_tgt[i]) begin m_tgt[i] = 0; m_tsk[i] = 0; end
    m_run = 0; m_req = 0; m_ovf = 0; m_idx = 0; m_cnt = 1; m_task = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!run && idx == 0 && cnt == 1 && !req && !ovf, "R10", "reset",
        {run, idx, cnt, req, ovf}, {1'b0, 6'd0, 6'd1, 1'b0, 1'b0});

    // R5 count bounds
    wr_cnt(0);  chk(cnt == 1, "R5", "cnt after 0", cnt, 1);
    wr_cnt(49); chk(cnt == 1, "R5", "cnt after 49", cnt, 1);
    wr_cnt(63); chk(cnt == 1, "R5", "cnt after 63", cnt, 1);
    wr_cnt(48); chk(cnt == 48, "R5", "cnt 48", cnt, 48);

    // R1 load table with nonzero targets
    for (int i = 0; i < 48; i++) wr_ent(i, $urandom | 32'h1, i + 100);

    // R3 full sweep with wrap at 48
    start = 1; cyc();
    for (int i = 0; i < 48; i++) begin
      pv = m_tgt[i]; cyc();
      chk(req && int'(rtask) == i + 100, "R1", "stored task", rtask, i + 100);
      ack = 1; pv = 0; cyc();
    end
    chk(idx == 0, "R3", "wrap to 0", idx, 0);

    // R4 pv to zero or other values leaves state alone
    pv = 0; repeat (3) cyc();
    chk(idx == 0 && run, "R4", "idle pv", idx, 0);

    // R9 write while running ignored
    wr_ent(0, 32'h5a5a5a5b, 8'd7);
    stop = 1; cyc();
    start = 1; cyc();
    pv = m_tgt[0]; cyc();
    chk(int'(rtask) == 100, "R9", "task after blocked write", rtask, 100);

    // R8 overflow: second match without ack
    pv = m_tgt[1]; cyc();
    chk(ovf == 1, "R8", "ovf set", ovf, 1);
    pv = 0; ack = 1; cyc();
    chk(ovf == 1, "R8", "ovf sticky", ovf, 1);

    // R6 start+stop together: stop wins, index held
    pv = m_tgt[m_idx];
    start = 1; stop = 1; cyc();
    chk(!run && idx == 2 && !req, "R6", "start+stop", {run, idx}, {1'b0, 6'd2});
    start = 1; cyc();
    chk(run && idx == 0 && !ovf, "R6", "start clears", {run, idx, ovf}, {1'b1, 6'd0, 1'b0});

    // R7 match coinciding with ack
    pv = m_tgt[0]; cyc();
    pv = m_tgt[1]; ack = 1; cyc();
    chk(req && !ovf && int'(rtask) == m_tsk[1], "R7", "ack+match", rtask, m_tsk[1]);

    // random phase with small counts
    stop = 1; cyc();
    wr_cnt(1 + int'($urandom_range(0, 5)));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) start = 1;
      else if (r < 5) stop = 1;
      else if (r < 7) begin cnt_we = 1; cnt_val = 6'($urandom_range(0, 63)); end
      if ($urandom_range(0, 9) < 2) begin
        tbl_we = 1; tbl_idx = 6'($urandom_range(0, 63));
        tbl_tgt = $urandom_range(0, 3); tbl_tsk = 8'($urandom);
      end
      ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) pv = m_tgt[m_idx];
      else pv = $urandom_range(0, 3);
      cyc();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule